// File: doc/BRIEF.md
# Delta-Sigma Converter Readout Sequencer

This block is the digital control side of a low-power converter that repeats a fixed loop: it converts, it sleeps while holding the result, and then it serves the result to a host over a three-wire serial link. A separate modulator model receives a one-cycle start strobe and answers with a done pulse and a 20-bit result. The block keeps that result in a shift register for as long as the host leaves chip select high. During that time it flags the low-power condition.

The host reads the value by pulling chip select low and toggling its own serial clock. The sequencer leaves sleep on the first rising serial-clock edge. It moves the next bit onto the data line after each falling edge, so the host can sample on rising edges. The word is 24 bits. The first bit is an end-of-conversion flag, followed by three fixed status bits and then the result, most significant bit first. The 24th falling edge ends the read. Raising chip select early also ends it. Either way a new conversion starts without any command. A host that sends 32 clocks receives ones after the word.

Top module: `adc_readout_seq`

## Requirements
- R1: After reset the block is converting and issues exactly one start strobe. The state order is fixed: sleep never goes directly back to conversion, and data output never goes back to sleep.
- R2: `conv_start_o` is a one-cycle pulse, raised once on every entry into conversion.
- R3: A done pulse during conversion captures `result_i` and moves to sleep. The captured word stays unchanged while in sleep, however `result_i` moves.
- R4: `low_power_o` is 1 only in sleep with chip select high. It is 0 in sleep once chip select is low.
- R5: In sleep with chip select low, SDO already presents bit 23 (end-of-conversion = 0). Output starts on the next serial-clock rising edge.
- R6: The word is 24 bits, MSB first: bit 23 is the end-of-conversion flag (0 = result ready), bits 22..20 are 000, and bits 19..0 are the result of the conversion just finished. SDO advances one bit after each falling serial-clock edge.
- R7: The 24th falling edge ends output and starts a conversion. While converting with chip select low, SDO reads 1, including for up to 8 extra clocks after the word.
- R8: Chip select going high during output abandons the read and starts a new conversion. The next read returns the next result in full.
- R9: `sdo_oe_o` is 1 exactly while the synchronized chip select is low. It is 0 while chip select is high.
- R10: A done pulse outside conversion is ignored. The held word still reads back the earlier result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, asynchronous |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the SDO pad driver |
| conv_start_o | output | 1 | One-cycle strobe that starts a conversion |
| conv_done_i | input | 1 | One-cycle pulse from the modulator: result valid |
| result_i | input | DATA_W (20) | Conversion result |
| low_power_o | output | 1 | Power-down indication |

## Verification
The bench builds the block with its defaults: 20 data bits, 4 status bits and two synchronizer stages. This keeps the full 24-bit word, the status prefix and the 32-clock padding within reach of one directed run. A serial-clock phase of six system cycles covers the three-cycle synchronizer and edge-detect delay. Each bit can therefore be sampled just before the next rising edge. The modulator model's latency can be changed at run time. A long latency keeps the block converting through the padding clocks, and a short one exercises aborted reads that resume quickly.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_OUT   = 2'd2
    } seq_state_e;

    // End-of-conversion flag value loaded with a fresh result
    localparam logic EOC_READY = 1'b0;
    // Value driven on SDO while a conversion is running
    localparam logic EOC_BUSY  = 1'b1;

endpackage

// File: rtl/adc_sync_bit.sv
module adc_sync_bit #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/adc_edge_det.sv
module adc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/adc_shift_word.sv
module adc_shift_word #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_val_i,
    input  logic              shift_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i)       word_d = load_val_i;
        else if (shift_i) word_d = {word_q[WORD_W-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '1;
        else        word_q <= word_d;
    end

    assign word_o = word_q;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_high_i,
    input  logic       sck_rise_i,
    input  logic       sck_fall_i,
    input  logic       conv_done_i,
    output logic       load_o,
    output logic       shift_o,
    output logic       conv_start_o,
    output logic       low_power_o,
    output seq_state_e state_o
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             launched;
        logic             start;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.start = 1'b0;
        load_o  = 1'b0;
        shift_o = 1'b0;
        unique case (r_q.state)
            ST_CONV: begin
                if (!r_q.launched) begin
                    r_d.start    = 1'b1;
                    r_d.launched = 1'b1;
                end else if (conv_done_i) begin
                    load_o      = 1'b1;
                    r_d.state   = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!cs_high_i && sck_rise_i) begin
                    r_d.state = ST_OUT;
                    r_d.cnt   = '0;
                end
            end
            ST_OUT: begin
                if (cs_high_i) begin
                    r_d.state    = ST_CONV;
                    r_d.launched = 1'b0;
                end else if (sck_fall_i) begin
                    shift_o = 1'b1;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.state    = ST_CONV;
                        r_d.launched = 1'b0;
                    end
                end
            end
            default: begin
                r_d.state    = ST_CONV;
                r_d.launched = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_CONV;
            r_q.cnt      <= '0;
            r_q.launched <= 1'b0;
            r_q.start    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_start_o = r_q.start;
    assign low_power_o  = (r_q.state == ST_SLEEP) && cs_high_i;
    assign state_o      = r_q.state;

endmodule

// File: rtl/adc_readout_seq.sv
module adc_readout_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W      = 20,
    parameter int STATUS_W    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              conv_start_o,
    input  logic              conv_done_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              low_power_o
);

    localparam int WORD_W  = STATUS_W + DATA_W;
    localparam int N_SYNC  = 2;
    localparam int IDX_CS  = 0;
    localparam int IDX_SCK = 1;

    logic [N_SYNC-1:0] raw_vec, sync_vec;
    logic              cs_sync, sck_sync, sck_rise, sck_fall;
    logic              load_en, shift_en;
    logic [WORD_W-1:0] load_word, shift_word;
    seq_state_e        seq_state;

    assign raw_vec = {sck_i, cs_n_i};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        adc_sync_bit #(
            .STAGES    (SYNC_STAGES),
            .RESET_VAL ((g == IDX_CS) ? 1'b1 : 1'b0)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw_vec[g]),
            .dout  (sync_vec[g])
        );
    end

    assign cs_sync  = sync_vec[IDX_CS];
    assign sck_sync = sync_vec[IDX_SCK];

    adc_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sck_sync),
        .rise_o  (sck_rise),
        .fall_o  (sck_fall)
    );

    adc_seq_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_high_i    (cs_sync),
        .sck_rise_i   (sck_rise),
        .sck_fall_i   (sck_fall),
        .conv_done_i  (conv_done_i),
        .load_o       (load_en),
        .shift_o      (shift_en),
        .conv_start_o (conv_start_o),
        .low_power_o  (low_power_o),
        .state_o      (seq_state)
    );

    assign load_word = {EOC_READY, {(STATUS_W-1){1'b0}}, result_i};

    adc_shift_word #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_en),
        .load_val_i (load_word),
        .shift_i    (shift_en),
        .word_o     (shift_word)
    );

    assign sdo_o    = (seq_state == ST_CONV) ? EOC_BUSY : shift_word[WORD_W-1];
    assign sdo_oe_o = ~cs_sync;

endmodule

// File: rtl/adc_readout_chk.sv
module adc_readout_chk
    import adc_seq_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_high,
    input seq_state_e        state,
    input logic [WORD_W-1:0] word,
    input logic              conv_start_o,
    input logic              low_power_o,
    input logic              sdo_o,
    input logic              sdo_oe_o
);

    assert_sleep_not_conv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP) |=> (state != ST_CONV));

    assert_out_not_sleep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT) |=> (state != ST_SLEEP));

    assert_start_in_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (state == ST_CONV));

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    assert_sleep_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) == ST_SLEEP) |-> $stable(word));

    assert_low_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_power_o |-> (state == ST_SLEEP && !sdo_oe_o));

    assert_busy_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && sdo_oe_o) |-> sdo_o);

    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUT && cs_high) |=> (state == ST_CONV));

    assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |-> !sdo_oe_o);

endmodule

bind adc_readout_seq adc_readout_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_high      (cs_sync),
    .state        (seq_state),
    .word         (shift_word),
    .conv_start_o (conv_start_o),
    .low_power_o  (low_power_o),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o)
);

// File: tb/adc_readout_seq_test.sv
module adc_readout_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 20;
    localparam int WORD_W     = 24;
    localparam int HALF_SCK   = 6;
    localparam int N_VEC      = 6;
    localparam logic [DATA_W-1:0] VEC [N_VEC] = '{
        20'hABCDE, 20'h00000, 20'hFFFFF, 20'h80001, 20'h5A5A5, 20'h12345
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdo, sdo_oe, conv_start, conv_done, low_power;
    logic [DATA_W-1:0] result_bus;

    logic              auto_done;
    logic [DATA_W-1:0] auto_res;
    logic              force_done = 1'b0;
    logic              force_sel  = 1'b0;
    logic [DATA_W-1:0] force_val  = '0;
    logic [DATA_W-1:0] next_val   = '0;
    int                conv_delay = 40;
    int                mod_cnt;
    int                starts;
    int                checks = 0;
    int                errors = 0;
    bit                finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign conv_done  = auto_done | force_done;
    assign result_bus = force_sel ? force_val : auto_res;

    adc_readout_seq uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n),
        .sck_i        (sck),
        .sdo_o        (sdo),
        .sdo_oe_o     (sdo_oe),
        .conv_start_o (conv_start),
        .conv_done_i  (conv_done),
        .result_i     (result_bus),
        .low_power_o  (low_power)
    );

    // Modulator stand-in and start-strobe counter
    always @(posedge clk) begin
        if (!rst_n) begin
            auto_done <= 1'b0;
            auto_res  <= '0;
            mod_cnt   <= 0;
            starts    <= 0;
        end else begin
            auto_done <= 1'b0;
            if (conv_start) begin
                starts  <= starts + 1;
                mod_cnt <= conv_delay;
            end else if (mod_cnt == 1) begin
                auto_done <= 1'b1;
                auto_res  <= next_val;
                mod_cnt   <= 0;
            end else if (mod_cnt > 1) begin
                mod_cnt <= mod_cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_pulse();
        sck = 1'b1;
        wait_cycles(HALF_SCK);
        sck = 1'b0;
        wait_cycles(HALF_SCK);
    endtask

    task automatic wait_sleep();
        for (int i = 0; i < 3000 && !low_power; i++) @(negedge clk);
        check(low_power == 1'b1, "R4 sleep with CS high", int'(low_power), 1);
    endtask

    // Read nbits of the word; compares each bit against exp_word
    task automatic read_bits(input logic [WORD_W-1:0] exp_word, input int nbits, input string req);
        int bad;
        bad = 0;
        cs_n = 1'b0;
        wait_cycles(HALF_SCK);
        check(sdo_oe == 1'b1, "R9 oe with CS low", int'(sdo_oe), 1);
        check(low_power == 1'b0, "R4 low power off with CS low", int'(low_power), 0);
        check(sdo == exp_word[WORD_W-1], "R5 first bit before clocking", int'(sdo), int'(exp_word[WORD_W-1]));
        for (int k = 0; k < nbits; k++) begin
            if (sdo !== exp_word[WORD_W-1-k]) begin
                bad++;
                $display("FAIL %s: bit %0d actual %0b expected %0b", req, WORD_W-1-k, sdo, exp_word[WORD_W-1-k]);
            end
            sck_pulse();
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    initial begin
        int s0;
        next_val = VEC[0];
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(4);
        // R1: reset state
        check(starts == 1, "R1 one start after reset", starts, 1);
        check(sdo_oe == 1'b0, "R9 oe off while CS high", int'(sdo_oe), 0);
        check(low_power == 1'b0, "R1 converting after reset", int'(low_power), 0);

        // Vector table: full reads, R6 word layout, R7 restart
        for (int i = 0; i < N_VEC; i++) begin
            wait_sleep();
            s0 = starts;
            read_bits({1'b0, 3'b000, VEC[i]}, WORD_W, "R6 word");
            check(starts == s0 + 1, "R7 restart after 24 clocks", starts, s0 + 1);
            check(sdo == 1'b1, "R7 busy flag with CS low", int'(sdo), 1);
            check(starts == s0 + 1, "R2 single strobe per entry", starts, s0 + 1);
            next_val = VEC[(i + 1) % N_VEC];
            cs_n = 1'b1;
            wait_cycles(HALF_SCK);
            check(sdo_oe == 1'b0, "R9 oe off after read", int'(sdo_oe), 0);
        end

        // R7: padding clocks to 32 keep returning ones
        wait_sleep();
        conv_delay = 400;
        read_bits({1'b0, 3'b000, VEC[0]}, WORD_W, "R6 word before padding");
        for (int p = 0; p < 8; p++) begin
            check(sdo == 1'b1, "R7 padding bit", int'(sdo), 1);
            sck_pulse();
        end
        conv_delay = 40;
        next_val = 20'h3C3C3;
        cs_n = 1'b1;

        // R3: hold in sleep while result_i wanders
        wait_sleep();
        force_sel = 1'b1;
        for (int j = 0; j < 50; j++) begin
            force_val = DATA_W'(j * 20'h1F3A7);
            wait_cycles(5);
        end
        force_sel = 1'b0;
        read_bits({1'b0, 3'b000, 20'h3C3C3}, WORD_W, "R3 held result");
        next_val = 20'h0F0F0;
        cs_n = 1'b1;

        // R10: done pulse in sleep is ignored
        wait_sleep();
        force_sel  = 1'b1;
        force_val  = 20'h77777;
        wait_cycles(1);
        force_done = 1'b1;
        wait_cycles(1);
        force_done = 1'b0;
        force_sel  = 1'b0;
        wait_cycles(6);
        check(low_power == 1'b1, "R10 still sleeping", int'(low_power), 1);
        read_bits({1'b0, 3'b000, 20'h0F0F0}, WORD_W, "R10 ignored done");
        next_val = 20'hC0DE5;
        cs_n = 1'b1;

        // R8: abort mid-word
        wait_sleep();
        s0 = starts;
        read_bits({1'b0, 3'b000, 20'hC0DE5}, 10, "R8 partial word");
        next_val = 20'h2468A;
        cs_n = 1'b1;
        wait_cycles(8);
        check(starts == s0 + 1, "R8 abort starts conversion", starts, s0 + 1);
        check(low_power == 1'b0, "R8 converting after abort", int'(low_power), 0);
        wait_sleep();
        read_bits({1'b0, 3'b000, 20'h2468A}, WORD_W, "R8 word after abort");
        cs_n = 1'b1;
        wait_cycles(10);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule